// File: doc/BRIEF.md
# Power Management Control Register

This block is an 8-bit status and control register for the power-management unit of a small microcontroller. Software reaches it through a plain register bus: a write strobe with write data, and read data that always shows the current contents. The register holds three control selects and one status flag. The first select chooses the low-voltage detect threshold and, with it, the range of the warning threshold. The second select picks the warning threshold inside that range. The third select chooses how deep the device sleeps when it enters stop mode. The flag reports that the chip has come back from the deep, partial-power-down stop.

The detect-threshold select and the stop-depth select are each locked after their first write, and each has its own unlock rule. The detect select stays locked until a power-on reset. The stop-depth select is unlocked again by any reset. Three reset inputs tell the block which kind of reset happened, and the bits that are cleared depend on that kind. Both threshold selects survive a low-voltage reset and any other non-power-on reset. Software clears the flag by writing a one to an acknowledge bit. The decoded threshold indices and the deep-stop enable come straight from the stored bits.

Top module: `pwr_ctl_reg`

## Requirements
- R1: Read data shows the detect select in bit 5, the warning select in bit 4, the recovery flag in bit 3 and the stop-depth select in bit 0; bits 7, 6, 2 and 1 always read 0.
- R2: After a power-on reset, the detect select takes the value of bit 5 from the first write only. Later writes leave it unchanged, and low-voltage or other resets do not unlock it.
- R3: After any reset, the stop-depth select takes the value of bit 0 from the first write only. Later writes leave it unchanged until the next reset of any kind.
- R4: The warning select takes bit 4 on every write.
- R5: A power-on reset clears every bit and both locks. It takes precedence when other reset inputs are asserted in the same cycle.
- R6: A low-voltage reset or another reset clears the flag and the stop-depth select, and keeps bits 5 and 4 unchanged.
- R7: A pulse on the deep-stop recovery input sets the flag, which reads 1 from the next cycle on.
- R8: A write with bit 2 set clears the flag; a write with bit 2 clear leaves the flag unchanged.
- R9: When a recovery pulse and an acknowledging write fall in the same cycle, the flag ends up 1.
- R10: warn_lvl equals {detect select, warning select} (codes 0 to 3), det_lvl equals the detect select, and deep_stop_en equals the stop-depth select (1 = deep stop, 0 = shallow stop).
- R11: A write that meets a locked bit still updates the other writable bits in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| lvd_rst | input | 1 | Low-voltage reset, synchronous, active high |
| sys_rst | input | 1 | Any other reset, synchronous, active high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| deep_exit | input | 1 | Pulse marking recovery from deep stop |
| warn_lvl | output | 2 | Warning threshold index |
| det_lvl | output | 1 | Detect threshold index |
| deep_stop_en | output | 1 | 1 selects deep stop, 0 shallow stop |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the recovery pulse and an acknowledging write. The second is a reset and either a recovery pulse or a second reset input. The bench drives both members of each pair in one vector and reads the register in the following cycle. It expects the flag to stay set when the pulse meets the acknowledge. It expects a reset to win over the pulse, and a power-on reset to win over a low-voltage reset, so that the detect select, which had been locked, is cleared and can be written again.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  localparam int REG_W    = 8;
  localparam int DSEL_BIT = 5;
  localparam int WSEL_BIT = 4;
  localparam int FLAG_BIT = 3;
  localparam int ACK_BIT  = 2;
  localparam int DEPTH_BIT = 0;
  localparam int WARN_W   = 2;

  // warning threshold index from the two select bits
  function automatic logic [WARN_W-1:0] warn_code(input logic dsel, input logic wsel);
    return {dsel, wsel};
  endfunction

  // assemble the read view; unlisted bits stay 0
  function automatic logic [REG_W-1:0] pack_rd(input logic dsel, input logic wsel,
                                               input logic flag, input logic depth);
    logic [REG_W-1:0] v;
    v = '0;
    v[DSEL_BIT]  = dsel;
    v[WSEL_BIT]  = wsel;
    v[FLAG_BIT]  = flag;
    v[DEPTH_BIT] = depth;
    return v;
  endfunction
endpackage

// File: rtl/pwr_once_bit.sv
module pwr_once_bit #(
  parameter bit KEEP_ON_SOFT = 1'b0
) (
  input  logic clk,
  input  logic hard_rst,
  input  logic soft_rst,
  input  logic wr_hit,
  input  logic wr_val,
  output logic val_o,
  output logic lock_o
);
  logic val_q, lock_q;
  logic take_w;

  assign take_w = wr_hit && !lock_q;

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      val_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (soft_rst) begin
      if (!KEEP_ON_SOFT) begin
        val_q  <= 1'b0;
        lock_q <= 1'b0;
      end
    end else if (take_w) begin
      val_q  <= wr_val;
      lock_q <= 1'b1;
    end
  end

  assign val_o  = val_q;
  assign lock_o = lock_q;

  // R2 R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    (wr_hit && lock_o) |=> $stable(val_o));

  // R2 R3
  first_write_chk: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
    (wr_hit && !lock_o) |=> (lock_o && (val_o == $past(wr_val))));

  generate
    if (KEEP_ON_SOFT) begin : g_keep
      // R6
      soft_keep_chk: assert property (@(posedge clk) disable iff (hard_rst)
        soft_rst |=> ($stable(val_o) && $stable(lock_o)));
    end else begin : g_clear
      // R6
      soft_clear_chk: assert property (@(posedge clk) disable iff (hard_rst)
        soft_rst |=> (!val_o && !lock_o));
    end
  endgenerate
endmodule

// File: rtl/pwr_recov_flag.sv
module pwr_recov_flag (
  input  logic clk,
  input  logic any_rst,
  input  logic set_evt,
  input  logic ack_evt,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (any_rst)      flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (ack_evt) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R7 R9
  set_wins_chk: assert property (@(posedge clk) disable iff (any_rst)
    set_evt |=> flag_o);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (any_rst)
    (ack_evt && !set_evt) |=> !flag_o);

  // R8
  flag_idle_chk: assert property (@(posedge clk) disable iff (any_rst)
    (!ack_evt && !set_evt) |=> $stable(flag_o));
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              por_rst,
  input  logic              lvd_rst,
  input  logic              sys_rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              deep_exit,
  output logic [WARN_W-1:0] warn_lvl,
  output logic              det_lvl,
  output logic              deep_stop_en
);
  // named internal events
  logic soft_rst_w, any_rst_w, ack_w;
  logic dsel_w, dsel_lock_w, depth_w, depth_lock_w, flag_w;
  logic wsel_q;
  logic unused_wr_bits;

  assign soft_rst_w = lvd_rst || sys_rst;
  assign any_rst_w  = por_rst || soft_rst_w;
  assign ack_w      = wr_en && wr_data[ACK_BIT];
  assign unused_wr_bits = ^{wr_data[7:6], wr_data[FLAG_BIT], wr_data[1]};

  pwr_once_bit #(.KEEP_ON_SOFT(1'b1)) u_dsel (
    .clk(clk), .hard_rst(por_rst), .soft_rst(soft_rst_w),
    .wr_hit(wr_en), .wr_val(wr_data[DSEL_BIT]),
    .val_o(dsel_w), .lock_o(dsel_lock_w)
  );

  pwr_once_bit #(.KEEP_ON_SOFT(1'b0)) u_depth (
    .clk(clk), .hard_rst(por_rst), .soft_rst(soft_rst_w),
    .wr_hit(wr_en), .wr_val(wr_data[DEPTH_BIT]),
    .val_o(depth_w), .lock_o(depth_lock_w)
  );

  pwr_recov_flag u_flag (
    .clk(clk), .any_rst(any_rst_w), .set_evt(deep_exit),
    .ack_evt(ack_w), .flag_o(flag_w)
  );

  always_ff @(posedge clk) begin
    if (por_rst)         wsel_q <= 1'b0;
    else if (soft_rst_w) wsel_q <= wsel_q;
    else if (wr_en)      wsel_q <= wr_data[WSEL_BIT];
  end

  assign rd_data      = pack_rd(dsel_w, wsel_q, flag_w, depth_w);
  assign warn_lvl     = warn_code(dsel_w, wsel_q);
  assign det_lvl      = dsel_w;
  assign deep_stop_en = depth_w;

  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (any_rst_w)
    (rd_data[7:6] == 2'b00) && (rd_data[ACK_BIT] == 1'b0) && (rd_data[1] == 1'b0));

  // R4
  wsel_write_chk: assert property (@(posedge clk) disable iff (any_rst_w)
    wr_en |=> (rd_data[WSEL_BIT] == $past(wr_data[WSEL_BIT])));

  // R6
  wsel_keep_chk: assert property (@(posedge clk) disable iff (por_rst)
    soft_rst_w |=> $stable(warn_lvl));

  // R10
  outputs_match_chk: assert property (@(posedge clk) disable iff (any_rst_w)
    (warn_lvl == rd_data[5:4]) && (det_lvl == rd_data[DSEL_BIT]) &&
    (deep_stop_en == rd_data[DEPTH_BIT]));

  // R11
  locked_partial_chk: assert property (@(posedge clk) disable iff (any_rst_w)
    (wr_en && dsel_lock_w && depth_lock_w) |=>
      (rd_data[WSEL_BIT] == $past(wr_data[WSEL_BIT])) && $stable(det_lvl) && $stable(deep_stop_en));
endmodule

// File: tb/sim_pwr_ctl_reg.sv
module sim_pwr_ctl_reg;
  logic       clk = 1'b0;
  logic       por_rst = 1'b1, lvd_rst = 1'b0, sys_rst = 1'b0;
  logic       wr_en = 1'b0, deep_exit = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] warn_lvl;
  logic       det_lvl, deep_stop_en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  pwr_ctl_reg u0 (
    .clk(clk), .por_rst(por_rst), .lvd_rst(lvd_rst), .sys_rst(sys_rst),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .deep_exit(deep_exit),
    .warn_lvl(warn_lvl), .det_lvl(det_lvl), .deep_stop_en(deep_stop_en)
  );

  // entry: {req, por, lvd, sys, wr, dx, wdata, expected read}
  localparam int N = 18;
  localparam logic [28:0] VEC [N] = '{
    {8'd5,  1'b1,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h00}, // R5 reset state
    {8'd2,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h31, 8'h31}, // R2 R3 R4 first writes
    {8'd11, 1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00, 8'h21}, // R11 locked bits hold, wsel moves
    {8'd7,  1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h29}, // R7 recovery sets flag
    {8'd8,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00, 8'h29}, // R8 write 0 to ack
    {8'd8,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h04, 8'h21}, // R8 ack clears
    {8'd9,  1'b0,1'b0,1'b0,1'b1,1'b1, 8'h14, 8'h39}, // R9 set beats ack
    {8'd6,  1'b0,1'b0,1'b1,1'b0,1'b0, 8'h00, 8'h30}, // R6 other reset keeps 5,4
    {8'd3,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h01, 8'h21}, // R3 depth relocked, R2 dsel still locked
    {8'd3,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h10, 8'h31}, // R3 depth locked
    {8'd6,  1'b0,1'b1,1'b0,1'b0,1'b1, 8'h00, 8'h30}, // R6 low-voltage reset beats pulse
    {8'd2,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00, 8'h20}, // R2 dsel lock survives
    {8'd3,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h01, 8'h20}, // R3 depth locked at 0
    {8'd5,  1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 8'h00}, // R5 power-on wins
    {8'd5,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h10, 8'h10}, // R5 locks cleared
    {8'd2,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'h21, 8'h00}, // R2 dsel locked at 0
    {8'd1,  1'b0,1'b0,1'b0,1'b1,1'b0, 8'hFF, 8'h10}, // R1 reserved bits read 0
    {8'd7,  1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h18}  // R7 flag again
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input int req, input logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL R%0d rd_data actual=%h expected=%h", req, rd_data, exp);
    end
    // R10 decoded outputs from the expected register bits
    chk("R10 warn_lvl", {6'b0, warn_lvl}, {6'b0, exp[5], exp[4]});
    chk("R10 det_lvl", {7'b0, det_lvl}, {7'b0, exp[5]});
    chk("R10 deep_stop_en", {7'b0, deep_stop_en}, {7'b0, exp[0]});
  endtask

  task automatic step(input logic p, input logic l, input logic s, input logic w,
                      input logic d, input logic [7:0] wd);
    por_rst = p; lvd_rst = l; sys_rst = s; wr_en = w; deep_exit = d; wr_data = wd;
    @(posedge clk);
    #3;
    por_rst = 1'b0; lvd_rst = 1'b0; sys_rst = 1'b0; wr_en = 1'b0; deep_exit = 1'b0;
    #2;
  endtask

  initial begin
    @(posedge clk); #3;
    for (int i = 0; i < N; i++) begin
      step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:8]);
      check_all(int'(VEC[i][28:21]), VEC[i][7:0]);
    end
    // directed: idle cycles leave everything alone (R8, R4)
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
    check_all(8, 8'h18);
    // directed: sys and low-voltage reset together keep bits 5,4 (R6)
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    check_all(6, 8'h10);
    // directed: power-on with a pending write, write ignored (R5)
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h31);
    check_all(5, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule